// File: doc/BRIEF.md
# Abstract Command Sequencer with Sticky Error Latch

This block sits between a debugger's register port and a hart. The debugger writes a command word. The block decides whether the command may start and raises a one-cycle start pulse towards the hart, carrying that word. It then holds a busy flag until the hart returns a done pulse with a three-bit result code. Any failure is kept in a sticky error field. While that field is non-zero, every new command is blocked, so a debugger can queue several commands and inspect the outcome once at the end.

The block also holds a small bank of argument words and program words. While a command runs, these words are protected: any access to them counts as a collision, and writes to them are dropped. An autoexec mask allows a plain read or write of a chosen argument or program word to launch the stored command again, which lets the debugger stream data without rewriting the command.

Top module: `acmd_seq`

## Requirements
- R1: The status word at offset 0x00 reads busy in bit 0, the error code in bits [6:4], the argument word count in bits [11:8] and the program word count in bits [20:16]. After reset, busy, the error code, the autoexec mask, the stored command and every stored word all read 0.
- R2: A command write (offset 0x01, type in bits [31:24]) of a supported type, made while busy is 0 and the error code is 0, makes busy read 1 from the next cycle. In that same cycle it gives exactly one go pulse carrying the written word. Busy stays 1 until the hart's done pulse.
- R3: While busy, a write to the status, command or autoexec offset, or any read or write of an argument or program word, sets the error code to 1 (busy collision) if it is 0. Otherwise the code is left unchanged.
- R4: While busy, writes to argument words, program words, the autoexec mask and the command register leave the stored values unchanged, and no further go pulse is produced.
- R5: While the error code is non-zero, command writes are dropped: the stored command is kept and there is no go pulse. Autoexec accesses launch nothing.
- R6: When not busy, writing the status offset clears each error-code bit whose matching bit in [6:4] of the written data is 1, and leaves the other bits as they are.
- R7: A command whose type is NTYPES or larger never produces a go pulse. It leaves busy at 0 and sets the error code to 2 (not supported) in the next cycle.
- R8: A done pulse clears busy on the edge that samples it. A non-zero done code (3 exception, 4 wrong hart state, 5 bus, 7 other, or any other non-zero value) is latched only if the error code is 0. A done code of 0 leaves the error code at 0.
- R9: When autoexec bit i (bits [11:0]) is set, a read or write of argument word i launches the stored command, subject to R5. Bit 16+j does the same for program word j. Accesses to words whose bit is clear launch nothing.
- R10: Autoexec bits for argument words at or above NDATA, for program words at or above NPROG, and for bits [15:12] and [31:16+NPROG] read back as 0 and cannot be set.
- R11: Argument word i is at offset 0x10+i and program word j at 0x20+j, and both read back what was written. Offsets beyond the implemented counts read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Register offset |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, combinational from the current offset |
| go_pulse | output | 1 | One-cycle command start towards the hart |
| go_word | output | 32 | Command word that goes with go_pulse |
| done_pulse | input | 1 | Hart reports that the command has finished |
| done_code | input | 3 | Result code that goes with done_pulse |

## Verification
The assertions assume that the hart raises done_pulse only while a command is running, holds it for one cycle, and never answers in the same cycle as the go pulse. They also assume at most one register access per cycle. The bench's hart stub waits for go_pulse, counts a programmable delay and then gives a single done pulse, so every done arrives inside a busy window. Collision stimulus is issued only while the stub's long delay keeps busy high, which keeps the start and finish of a command away from any debugger access.

// File: rtl/acmd_pkg.sv
package acmd_pkg;

    localparam int ADDR_W = 6;
    localparam int WORD_W = 32;

    // result codes shared by the sticky error field and the hart response
    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;
    localparam logic [2:0] ERR_STATE = 3'd4;
    localparam logic [2:0] ERR_BUS   = 3'd5;
    localparam logic [2:0] ERR_OTHER = 3'd7;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 6'h01;
    localparam logic [ADDR_W-1:0] OFS_AUTO   = 6'h02;
    localparam logic [1:0]        BANK_ARG   = 2'b01;
    localparam logic [1:0]        BANK_PROG  = 2'b10;
    localparam int                AUTO_PROG_LSB = 16;

    typedef struct packed {
        logic       hit_status;
        logic       hit_cmd;
        logic       hit_auto;
        logic       hit_data;
        logic       hit_prog;
        logic [3:0] idx;
    } dec_t;

    function automatic logic [WORD_W-1:0] status_word(
        input logic       busy,
        input logic [2:0] err,
        input logic [3:0] nd,
        input logic [4:0] np
    );
        return {11'b0, np, 4'b0, nd, 1'b0, err, 3'b0, busy};
    endfunction

    function automatic logic [WORD_W-1:0] auto_mask(input int nd, input int np);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < nd; i++) m[i] = 1'b1;
        for (int j = 0; j < np; j++) m[AUTO_PROG_LSB + j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/acmd_decode.sv
module acmd_decode
    import acmd_pkg::*;
#(
    parameter int NDATA = 4,
    parameter int NPROG = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [4:0] ND5 = 5'(NDATA);
    localparam logic [4:0] NP5 = 5'(NPROG);

    always_comb begin
        dec            = '0;
        dec.idx        = addr[3:0];
        dec.hit_status = (addr == OFS_STATUS);
        dec.hit_cmd    = (addr == OFS_CMD);
        dec.hit_auto   = (addr == OFS_AUTO);
        dec.hit_data   = (addr[5:4] == BANK_ARG)  && ({1'b0, addr[3:0]} < ND5);
        dec.hit_prog   = (addr[5:4] == BANK_PROG) && ({1'b0, addr[3:0]} < NP5);
    end

endmodule

// File: rtl/acmd_store.sv
module acmd_store
    import acmd_pkg::*;
#(
    parameter int NDATA = 4,
    parameter int NPROG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel_prog,
    input  logic [3:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] data_rd;
    logic [WORD_W-1:0] prog_rd;

    logic [WORD_W-1:0] dmem [NDATA];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDATA; i++) dmem[i] <= '0;
        end else begin
            for (int i = 0; i < NDATA; i++)
                if (we && !sel_prog && idx == 4'(i)) dmem[i] <= wdata;
        end
    end

    always_comb begin
        data_rd = '0;
        for (int i = 0; i < NDATA; i++)
            if (idx == 4'(i)) data_rd = dmem[i];
    end

    generate
        if (NPROG > 0) begin : g_prog
            logic [WORD_W-1:0] pmem [NPROG];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < NPROG; j++) pmem[j] <= '0;
                end else begin
                    for (int j = 0; j < NPROG; j++)
                        if (we && sel_prog && idx == 4'(j)) pmem[j] <= wdata;
                end
            end

            always_comb begin
                prog_rd = '0;
                for (int j = 0; j < NPROG; j++)
                    if (idx == 4'(j)) prog_rd = pmem[j];
            end
        end else begin : g_noprog
            assign prog_rd = '0;
        end
    endgenerate

    assign rd_word = sel_prog ? prog_rd : data_rd;

endmodule

// File: rtl/acmd_ctrl.sv
module acmd_ctrl
    import acmd_pkg::*;
#(
    parameter int NDATA  = 4,
    parameter int NPROG  = 3,
    parameter int NTYPES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  dec_t              dec,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              done_in,
    input  logic [2:0]        done_err,
    output logic              busy,
    output logic [2:0]        err,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] auto_bits,
    output logic              go,
    output logic [WORD_W-1:0] go_cmd,
    output logic              store_we
);
    localparam logic [WORD_W-1:0] AUTO_MASK = auto_mask(NDATA, NPROG);
    localparam logic [7:0]        NT8       = 8'(NTYPES);

    logic              busy_q, go_q;
    logic [2:0]        err_q, err_n;
    logic [WORD_W-1:0] cmd_q, aut_q, go_cmd_q;

    logic wr_cmd, wr_stat, wr_auto, mem_acc, auto_sel;
    logic collide, idle_ok, launch, supported, hart_fail, start;
    logic [WORD_W-1:0] next_word;

    always_comb begin
        wr_cmd    = req_valid && req_write && dec.hit_cmd;
        wr_stat   = req_valid && req_write && dec.hit_status;
        wr_auto   = req_valid && req_write && dec.hit_auto;
        mem_acc   = req_valid && (dec.hit_data || dec.hit_prog);
        auto_sel  = dec.hit_data ? aut_q[{1'b0, dec.idx}]
                                 : aut_q[5'(AUTO_PROG_LSB) + {1'b0, dec.idx}];
        collide   = busy_q && (wr_cmd || wr_stat || wr_auto || mem_acc);
        idle_ok   = !busy_q && (err_q == ERR_NONE);
        launch    = idle_ok && (wr_cmd || (mem_acc && auto_sel));
        next_word = wr_cmd ? req_wdata : cmd_q;
        supported = next_word[31:24] < NT8;
        start     = launch && supported;
        hart_fail = busy_q && done_in && (done_err != ERR_NONE);
    end

    // error latch: only a status write clears bits; every set needs a zero field
    always_comb begin
        err_n = err_q;
        if (wr_stat && !busy_q)
            err_n = err_q & ~req_wdata[6:4];
        if (launch && !supported)
            err_n = ERR_UNSUP;
        else if (hart_fail && err_q == ERR_NONE)
            err_n = done_err;
        else if (collide && err_q == ERR_NONE)
            err_n = ERR_BUSY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            err_q    <= ERR_NONE;
            cmd_q    <= '0;
            aut_q    <= '0;
            go_q     <= 1'b0;
            go_cmd_q <= '0;
        end else begin
            if (start)
                busy_q <= 1'b1;
            else if (busy_q && done_in)
                busy_q <= 1'b0;
            err_q <= err_n;
            if (wr_cmd && idle_ok)
                cmd_q <= req_wdata;
            if (wr_auto && !busy_q)
                aut_q <= req_wdata & AUTO_MASK;
            go_q <= start;
            if (start)
                go_cmd_q <= next_word;
        end
    end

    assign busy      = busy_q;
    assign err       = err_q;
    assign cmd_word  = cmd_q;
    assign auto_bits = aut_q;
    assign go        = go_q;
    assign go_cmd    = go_cmd_q;
    assign store_we  = req_valid && req_write && (dec.hit_data || dec.hit_prog) && !busy_q;

    a_r2_go_while_busy: assert property (@(posedge clk) disable iff (rst)
        go_q |-> busy_q);
    a_r2_go_single: assert property (@(posedge clk) disable iff (rst)
        go_q |=> !go_q);
    a_r3_collision_sets: assert property (@(posedge clk) disable iff (rst)
        (collide && err_q == ERR_NONE && !hart_fail) |=> (err_q == ERR_BUSY));
    a_r5_no_go_on_error: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_NONE) |=> !go_q);
    a_r6_sticky_error: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_NONE && !(wr_stat && !busy_q)) |=> $stable(err_q));
    a_r7_unsupported: assert property (@(posedge clk) disable iff (rst)
        (launch && !supported) |=> (!busy_q && !go_q && err_q == ERR_UNSUP));
    a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done_in) |=> !busy_q);
    a_r10_auto_mask: assert property (@(posedge clk) disable iff (rst)
        (aut_q & ~AUTO_MASK) == '0);

endmodule

// File: rtl/acmd_seq.sv
module acmd_seq
    import acmd_pkg::*;
#(
    parameter int NDATA  = 4,
    parameter int NPROG  = 3,
    parameter int NTYPES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [5:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] req_rdata,
    output logic        go_pulse,
    output logic [31:0] go_word,
    input  logic        done_pulse,
    input  logic [2:0]  done_code
);
    localparam logic [3:0] ND4 = 4'(NDATA);
    localparam logic [4:0] NP5 = 5'(NPROG);

    dec_t              dec;
    logic              busy, st_we;
    logic [2:0]        err;
    logic [WORD_W-1:0] cmd_word, auto_bits, st_rd;

    acmd_decode #(.NDATA(NDATA), .NPROG(NPROG)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    acmd_ctrl #(.NDATA(NDATA), .NPROG(NPROG), .NTYPES(NTYPES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .dec       (dec),
        .req_wdata (req_wdata),
        .done_in   (done_pulse),
        .done_err  (done_code),
        .busy      (busy),
        .err       (err),
        .cmd_word  (cmd_word),
        .auto_bits (auto_bits),
        .go        (go_pulse),
        .go_cmd    (go_word),
        .store_we  (st_we)
    );

    acmd_store #(.NDATA(NDATA), .NPROG(NPROG)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .sel_prog (dec.hit_prog),
        .idx      (dec.idx),
        .wdata    (req_wdata),
        .rd_word  (st_rd)
    );

    always_comb begin
        req_rdata = '0;
        if (dec.hit_status)
            req_rdata = status_word(busy, err, ND4, NP5);
        else if (dec.hit_cmd)
            req_rdata = cmd_word;
        else if (dec.hit_auto)
            req_rdata = auto_bits;
        else if (dec.hit_data || dec.hit_prog)
            req_rdata = st_rd;
    end

    a_r4_no_store_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !st_we);

endmodule

// File: tb/tb_acmd_seq.sv
module tb_acmd_seq;
    localparam int ND = 4;
    localparam int NP = 3;
    localparam int NT = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [5:0]  req_addr;
    logic [31:0] req_wdata, req_rdata;
    logic        go_pulse;
    logic [31:0] go_word;
    logic        done_pulse;
    logic [2:0]  done_code;

    int checks = 0, fails = 0;
    int go_count = 0;
    logic [31:0] last_go = '0;
    int stub_lat = 3;
    logic [2:0] stub_err = 3'd0;

    always #10 clk = ~clk;

    acmd_seq #(.NDATA(ND), .NPROG(NP), .NTYPES(NT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .go_pulse(go_pulse), .go_word(go_word),
        .done_pulse(done_pulse), .done_code(done_code)
    );

    function automatic logic [31:0] stat(input logic b, input logic [2:0] e);
        return 32'(b) | (32'(e) << 4) | (32'(ND) << 8) | (32'(NP) << 16);
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [5:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #5 r = req_rdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic [31:0] r;
        acc(1'b1, a, d, r);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] r);
        acc(1'b0, a, 32'h0, r);
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int k = 0; k < 200; k++) begin
            rd(6'h00, r);
            if (r[0] == 1'b0) break;
        end
    endtask

    // hart stub
    initial begin
        done_pulse = 1'b0;
        done_code  = 3'd0;
        forever begin
            @(negedge clk);
            if (go_pulse === 1'b1) begin
                go_count++;
                last_go = go_word;
                repeat (stub_lat) @(negedge clk);
                done_code  = stub_err;
                done_pulse = 1'b1;
                @(negedge clk);
                done_pulse = 1'b0;
                done_code  = 3'd0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] r, w;
        int g;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(6'h00, r); chk("R1 status after reset", r, stat(0, 0));
        rd(6'h01, r); chk("R1 command after reset", r, 32'h0);
        rd(6'h02, r); chk("R1 autoexec after reset", r, 32'h0);
        for (int i = 0; i < ND; i++) begin rd(6'(16 + i), r); chk("R1 arg word reset", r, 32'h0); end
        for (int j = 0; j < NP; j++) begin rd(6'(32 + j), r); chk("R1 prog word reset", r, 32'h0); end

        // R11 storage sweep
        for (int i = 0; i < ND; i++) wr(6'(16 + i), 32'h1000_0000 + 32'(i) * 32'h0101_0101);
        for (int j = 0; j < NP; j++) wr(6'(32 + j), 32'h2000_0000 + 32'(j) * 32'h0011_0011);
        for (int i = 0; i < ND; i++) begin
            rd(6'(16 + i), r); chk("R11 arg readback", r, 32'h1000_0000 + 32'(i) * 32'h0101_0101);
        end
        for (int j = 0; j < NP; j++) begin
            rd(6'(32 + j), r); chk("R11 prog readback", r, 32'h2000_0000 + 32'(j) * 32'h0011_0011);
        end
        wr(6'(16 + ND), 32'hFFFF_FFFF); rd(6'(16 + ND), r); chk("R11 arg beyond count", r, 32'h0);
        wr(6'(32 + NP), 32'hFFFF_FFFF); rd(6'(32 + NP), r); chk("R11 prog beyond count", r, 32'h0);

        // R10 autoexec mask
        wr(6'h02, 32'hFFFF_FFFF); rd(6'h02, r);
        chk("R10 autoexec mask", r, ((32'h1 << ND) - 1) | (((32'h1 << NP) - 1) << 16));
        wr(6'h02, 32'h0);

        // R2 / R7 sweep over all type codes
        stub_lat = 3; stub_err = 3'd0;
        for (int t = 0; t < 8; t++) begin
            g = go_count;
            w = (32'(t) << 24) | 32'h00_AB00 | 32'(t);
            wr(6'h01, w);
            rd(6'h00, r);
            if (t < NT) begin
                chk("R2 busy after command write", r, stat(1, 0));
                wait_idle();
                chk("R2 one go pulse", 32'(go_count), 32'(g + 1));
                chk("R2 go word", last_go, w);
                rd(6'h00, r); chk("R8 clean done leaves no error", r, stat(0, 0));
            end else begin
                chk("R7 unsupported type", r, stat(0, 2));
                chk("R7 no go pulse", 32'(go_count), 32'(g));
                wr(6'h00, 32'h70);
                rd(6'h00, r); chk("R6 full clear", r, stat(0, 0));
            end
        end

        // R8 hart error codes
        for (int c = 1; c < 8; c++) begin
            if (c == 6) continue;
            stub_err = 3'(c);
            wr(6'h01, 32'h0100_0001);
            wait_idle();
            rd(6'h00, r); chk("R8 hart error latched", r, stat(0, 3'(c)));
            wr(6'h00, 32'h70);
        end

        // R6 partial clears from 7
        stub_err = 3'd7;
        wr(6'h01, 32'h0100_0002); wait_idle();
        wr(6'h00, 32'h20); rd(6'h00, r); chk("R6 clear bit 5", r, stat(0, 5));
        wr(6'h00, 32'h40); rd(6'h00, r); chk("R6 clear bit 6", r, stat(0, 1));
        wr(6'h00, 32'h10); rd(6'h00, r); chk("R6 clear bit 4", r, stat(0, 0));
        stub_err = 3'd0;

        // R3 / R4 collisions during a long command
        stub_lat = 20;
        rd(6'h10, w);
        wr(6'h01, 32'h0000_0033);
        wr(6'h10, 32'hDEAD_BEEF);
        wait_idle();
        rd(6'h00, r); chk("R3 arg write collision", r, stat(0, 1));
        rd(6'h10, r); chk("R4 arg word kept", r, w);
        wr(6'h00, 32'h70);

        g = go_count;
        wr(6'h01, 32'h0000_0033);
        rd(6'h20, r);
        wr(6'h02, 32'h0000_000F);
        wr(6'h01, 32'h0100_0077);
        wait_idle();
        rd(6'h00, r); chk("R3 prog read collision", r, stat(0, 1));
        rd(6'h02, r); chk("R4 autoexec kept", r, 32'h0);
        rd(6'h01, r); chk("R4 command kept", r, 32'h0000_0033);
        chk("R4 no extra go", 32'(go_count), 32'(g + 1));
        wr(6'h00, 32'h70);

        stub_err = 3'd5;
        wr(6'h01, 32'h0000_0033);
        wr(6'h11, 32'h1234_5678);
        wait_idle();
        rd(6'h00, r); chk("R8 hart error not over collision", r, stat(0, 1));
        wr(6'h00, 32'h70);
        stub_err = 3'd0;

        wr(6'h01, 32'h0000_0033);
        wr(6'h00, 32'h70);
        wait_idle();
        rd(6'h00, r); chk("R3 status write collision", r, stat(0, 1));
        wr(6'h00, 32'h70);

        // R5 commands dropped while error held
        stub_lat = 3;
        wr(6'h01, 32'h0700_0000);
        g = go_count;
        wr(6'h01, 32'h0000_0044);
        rd(6'h01, r); chk("R5 command not stored", r, 32'h0700_0000);
        wr(6'h02, 32'h1);
        rd(6'h10, r);
        rd(6'h00, r); chk("R5 error kept", r, stat(0, 2));
        chk("R5 no go while error", 32'(go_count), 32'(g));
        wr(6'h00, 32'h70);
        wr(6'h02, 32'h0);

        // R9 autoexec relaunch
        wr(6'h01, 32'h0200_0099); wait_idle();
        g = go_count;
        wr(6'h02, (32'h1 << 1) | (32'h1 << 18));
        rd(6'h11, r); wait_idle();
        chk("R9 arg read relaunch", 32'(go_count), 32'(g + 1));
        chk("R9 relaunch word", last_go, 32'h0200_0099);
        wr(6'h11, 32'h55); wait_idle();
        chk("R9 arg write relaunch", 32'(go_count), 32'(g + 2));
        rd(6'h10, r); rd(6'h21, r); wait_idle();
        chk("R9 clear bits launch nothing", 32'(go_count), 32'(g + 2));
        wr(6'h22, 32'h66); wait_idle();
        chk("R9 prog write relaunch", 32'(go_count), 32'(g + 3));
        rd(6'h11, r); chk("R9 arg write landed", r, 32'h55);
        wait_idle();
        chk("R9 arg read relaunch again", 32'(go_count), 32'(g + 4));
        rd(6'h00, r); chk("R9 no error", r, stat(0, 0));

        report();
        $finish;
    end

endmodule